// File: doc/BRIEF.md
# Multi-Bank DRAM Command Issue Arbiter

This block sits in front of one DRAM channel and decides, every memory cycle, which single command goes out. Incoming requests (an address plus a read/write flag) are sorted by their target bank into small per-bank queues. Each cycle the arbiter scans every bank once, starting just past the bank it served last. It issues the first bank head (or pending refresh) whose bank is idle and whose bus timing allows it.

Bus timing follows a closed-bank, fixed-slot command model. Three shared down-counters keep the data bus legal. A base counter spaces all commands. A write counter adds a read-to-write turnaround. A new-rank counter adds a bubble when a read moves to a rank other than the one used last. A per-bank busy counter keeps a bank closed for its recovery time after each access. Refreshes fall due at a fixed rate, walk a pointer over all banks and borrow the same slots as requests.

Two sets of enable inputs come from outside. One is a per-rank flag that allows an activate, driven by an activate-window tracker. The other is a per-bank flag that grants a request permission, driven by an age/batch policy.

Top module: `dram_issue_arb`

## Requirements
- R1: The bank index is dimm*(RANKS_PER_DIMM*BANKS_PER_RANK) + rank*BANKS_PER_RANK + bank. The bank field is taken from address bit BANK_LSB (default 6, 2 bits), the rank field from RANK_LSB (default 8, 1 bit) and the dimm field from DIMM_LSB (default 9, 1 bit). Every other address bit is ignored.
- R2: A request or refresh issues only when its bank has been idle for BANK_BUSY cycles since its last command (default 6) and at least BUS_BUSY cycles (default 2) have passed since any command.
- R3: After a read, a write may issue no sooner than BUS_BUSY+RW_DELAY cycles later (default 3). A read to a different rank may issue no sooner than BUS_BUSY+RR_DELAY cycles later (default 3). A read to the same rank waits only BUS_BUSY cycles.
- R4: After a write or a refresh, any other command may issue BUS_BUSY cycles later, whatever its type or rank.
- R5: A bank's head request issues only while old_ok[bank] and act_ok[rank] are both high. These inputs act in the same cycle.
- R6: Each bank queue holds FIFO_DEPTH entries (default 2). in_ready is low exactly when the addressed bank's queue is full, and nothing is accepted while it is low. Entries issue in arrival order, no earlier than the cycle after acceptance.
- R7: The scan starts at the bank after the last issued command and takes the first eligible bank in rising, wrapping order.
- R8: One refresh becomes pending every REFRESH_PERIOD/NBANK cycles, the first one in the cycle after reset is released. Refreshes go to banks 0,1,2,... and wrap after NBANK-1. Pending refreshes accumulate and the count never reaches ten.
- R9: A refresh needs its bank idle, the base bus counter at zero and act_ok of its rank high. It ignores old_ok. When it is held back, the pending refreshes afterwards issue BUS_BUSY cycles apart.
- R10: At most one command issues per cycle. When a refresh and a request of the same bank are both eligible, the refresh goes first.
- R11: After a synchronous active-high reset, the queues are empty, no command issues and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present at the input |
| in_addr | input | ADDR_W | Request address |
| in_write | input | 1 | 1 = write, 0 = read |
| in_ready | output | 1 | Addressed bank queue has room; request taken at the clock edge when in_valid is high |
| act_ok | input | NRANK | Per-rank activate permission |
| old_ok | input | NBANK | Per-bank request permission |
| iss_valid | output | 1 | A command issues this cycle |
| iss_refresh | output | 1 | Issued command is a refresh |
| iss_write | output | 1 | Issued request is a write (0 for reads and refreshes) |
| iss_bank | output | BIDX_W | Bank index of the issued command |

## Verification
The issue outputs are combinational from registered state and the two enable inputs. A request accepted at a clock edge can therefore issue in the cycle right after that edge, and raising old_ok or act_ok releases a waiting head in that same cycle. Every turnaround is a whole number of cycles after the previous command: BUS_BUSY, BUS_BUSY plus a bubble, or BANK_BUSY for the same bank. The first refresh appears one cycle after reset is released, and later ones come at fixed intervals. The bench logs each issue with its cycle number, sampled on the falling clock edge, and compares the logged cycles with values derived from these rules.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

  // Global bank number from the address fields; each field is masked to its count.
  function automatic int unsigned bank_index(input logic [63:0] addr,
                                             input int unsigned bank_lsb,
                                             input int unsigned rank_lsb,
                                             input int unsigned dimm_lsb,
                                             input int unsigned nbank,
                                             input int unsigned nrank,
                                             input int unsigned ndimm);
    int unsigned d, r, b;
    d = 32'((addr >> dimm_lsb) & 64'(ndimm - 1));
    r = 32'((addr >> rank_lsb) & 64'(nrank - 1));
    b = 32'((addr >> bank_lsb) & 64'(nbank - 1));
    return d * nrank * nbank + r * nbank + b;
  endfunction

  // Rank that owns a global bank number.
  function automatic int unsigned rank_of(input int unsigned bank,
                                          input int unsigned banks_per_rank);
    return bank / banks_per_rank;
  endfunction

endpackage

// File: rtl/dram_bank_fifo.sv
module dram_bank_fifo #(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              nonempty,
  output logic [DATA_W-1:0] head
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign nonempty = (count != '0);
  assign head     = mem[rd_ptr];

  // R6
  fifo_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
  // R6
  fifo_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && !nonempty));
endmodule

// File: rtl/dram_bus_timer.sv
module dram_bus_timer #(
  parameter int BUS_BUSY = 2,
  parameter int RW_DELAY = 1,
  parameter int RR_DELAY = 1,
  parameter int RANK_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_req,
  input  logic              fire_ref,
  input  logic              fire_write,
  input  logic [RANK_W-1:0] fire_rank,
  output logic              basic_free,
  output logic              write_free,
  output logic              newrank_free,
  output logic [RANK_W-1:0] last_rank
);
  localparam int LD_BASIC = BUS_BUSY - 1;
  localparam int LD_WR_RD = BUS_BUSY + RW_DELAY - 1;
  localparam int LD_NR_RD = BUS_BUSY + RR_DELAY - 1;
  localparam int MAX_A    = (LD_WR_RD > LD_NR_RD) ? LD_WR_RD : LD_NR_RD;
  localparam int MAX_LD   = (MAX_A > LD_BASIC) ? MAX_A : LD_BASIC;
  localparam int CW       = (MAX_LD > 0) ? $clog2(MAX_LD + 1) : 1;

  logic [CW-1:0] basic_cnt, wr_cnt, nr_cnt;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      basic_cnt <= '0;
      wr_cnt    <= '0;
      nr_cnt    <= '0;
      last_rank <= '0;
    end else begin
      if (fire_ref || (fire_req && fire_write)) begin
        basic_cnt <= CW'(LD_BASIC);
        wr_cnt    <= CW'(LD_BASIC);
        nr_cnt    <= CW'(LD_BASIC);
      end else if (fire_req) begin
        basic_cnt <= CW'(LD_BASIC);
        wr_cnt    <= CW'(LD_WR_RD);
        nr_cnt    <= CW'(LD_NR_RD);
      end else begin
        basic_cnt <= step_down(basic_cnt);
        wr_cnt    <= step_down(wr_cnt);
        nr_cnt    <= step_down(nr_cnt);
      end
      if (fire_req) last_rank <= fire_rank;
    end
  end

  assign basic_free   = (basic_cnt == '0);
  assign write_free   = (wr_cnt == '0);
  assign newrank_free = (nr_cnt == '0);

  // R2
  bus_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_req || fire_ref) |-> (basic_cnt == '0));
  // R3
  write_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_req && fire_write) |-> (wr_cnt == '0));
  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !(fire_req && fire_ref));
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
  parameter int NBANK    = 16,
  parameter int INTERVAL = 128,
  parameter int BIDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  output logic              pending,
  output logic [BIDX_W-1:0] target
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] tick_cnt;
  logic [3:0]    pend;
  logic          tick;

  assign tick = (tick_cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= CW'(1);
      pend     <= '0;
      target   <= '0;
    end else begin
      tick_cnt <= tick ? CW'(INTERVAL) : tick_cnt - 1'b1;
      pend     <= pend + 4'(tick) - 4'(fire);
      if (fire) target <= (int'(target) == NBANK - 1) ? '0 : target + 1'b1;
    end
  end

  assign pending = (pend != '0);

  // R8
  pend_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pend < 4'd10);
  // R8
  ref_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && int'(target) == NBANK - 1) |=> (target == '0));
  // R9
  ref_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> pending);
endmodule

// File: rtl/dram_issue_arb.sv
module dram_issue_arb
  import dram_arb_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int NUM_DIMMS      = 2,
  parameter int RANKS_PER_DIMM = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int BANK_LSB       = 6,
  parameter int RANK_LSB       = 8,
  parameter int DIMM_LSB       = 9,
  parameter int FIFO_DEPTH     = 2,
  parameter int BANK_BUSY      = 6,
  parameter int BUS_BUSY       = 2,
  parameter int RW_DELAY       = 1,
  parameter int RR_DELAY       = 1,
  parameter int REFRESH_PERIOD = 2048,
  localparam int NBANK  = NUM_DIMMS * RANKS_PER_DIMM * BANKS_PER_RANK,
  localparam int NRANK  = NUM_DIMMS * RANKS_PER_DIMM,
  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  output logic              in_ready,
  input  logic [NRANK-1:0]  act_ok,
  input  logic [NBANK-1:0]  old_ok,
  output logic              iss_valid,
  output logic              iss_refresh,
  output logic              iss_write,
  output logic [BIDX_W-1:0] iss_bank
);
  localparam int REF_INTERVAL = REFRESH_PERIOD / NBANK;
  localparam int BB_LD        = BANK_BUSY - 1;
  localparam int BB_W         = (BANK_BUSY > 1) ? $clog2(BANK_BUSY) : 1;

  // Named internal events
  logic [BIDX_W-1:0] in_bank;
  logic [NBANK-1:0]  fifo_full, fifo_ne, head_wr, bank_free;
  logic              basic_free, write_free, newrank_free;
  logic [RANK_W-1:0] last_rank;
  logic              ref_pending;
  logic [BIDX_W-1:0] ref_target;
  logic [BIDX_W-1:0] rr_ptr;
  logic              found, pick_ref;
  logic [BIDX_W-1:0] pick_bank;
  logic              req_fire, ref_fire;
  logic [RANK_W-1:0] pick_rank;

  assign in_bank  = BIDX_W'(bank_index(64'(in_addr), BANK_LSB, RANK_LSB, DIMM_LSB,
                                       BANKS_PER_RANK, RANKS_PER_DIMM, NUM_DIMMS));
  assign in_ready = !fifo_full[in_bank];

  // Rotating scan: refresh of a bank is considered before its request.
  always_comb begin
    found     = 1'b0;
    pick_ref  = 1'b0;
    pick_bank = rr_ptr;
    for (int i = 1; i <= NBANK; i++) begin
      logic [BIDX_W-1:0] b;
      logic [RANK_W-1:0] rk;
      logic              ref_ok, req_ok, data_ok;
      b       = BIDX_W'((int'(rr_ptr) + i) % NBANK);
      rk      = RANK_W'(rank_of(int'(b), BANKS_PER_RANK));
      ref_ok  = ref_pending && (ref_target == b) && bank_free[b] && basic_free && act_ok[rk];
      data_ok = head_wr[b] ? write_free : ((rk == last_rank) || newrank_free);
      req_ok  = fifo_ne[b] && bank_free[b] && basic_free && act_ok[rk] && old_ok[b] && data_ok;
      if (!found && ref_ok) begin
        found = 1'b1; pick_ref = 1'b1; pick_bank = b;
      end else if (!found && req_ok) begin
        found = 1'b1; pick_ref = 1'b0; pick_bank = b;
      end
    end
  end

  assign req_fire  = found && !pick_ref;
  assign ref_fire  = found && pick_ref;
  assign pick_rank = RANK_W'(rank_of(int'(pick_bank), BANKS_PER_RANK));

  always_ff @(posedge clk) begin
    if (rst)        rr_ptr <= '0;
    else if (found) rr_ptr <= pick_bank;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [BB_W-1:0] busy;
    logic            hit;
    assign hit = found && (pick_bank == BIDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)               busy <= '0;
      else if (hit)          busy <= BB_W'(BB_LD);
      else if (busy != '0)   busy <= busy - 1'b1;
    end
    assign bank_free[g] = (busy == '0);

    dram_bank_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(1)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (in_valid && in_ready && (in_bank == BIDX_W'(g))),
      .push_data (in_write),
      .pop       (req_fire && (pick_bank == BIDX_W'(g))),
      .full      (fifo_full[g]),
      .nonempty  (fifo_ne[g]),
      .head      (head_wr[g])
    );

    // R2
    bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
      hit |-> (busy == '0));
  end

  dram_bus_timer #(
    .BUS_BUSY (BUS_BUSY),
    .RW_DELAY (RW_DELAY),
    .RR_DELAY (RR_DELAY),
    .RANK_W   (RANK_W)
  ) u_bus (
    .clk          (clk),
    .rst          (rst),
    .fire_req     (req_fire),
    .fire_ref     (ref_fire),
    .fire_write   (head_wr[pick_bank]),
    .fire_rank    (pick_rank),
    .basic_free   (basic_free),
    .write_free   (write_free),
    .newrank_free (newrank_free),
    .last_rank    (last_rank)
  );

  dram_refresh_ctl #(
    .NBANK    (NBANK),
    .INTERVAL (REF_INTERVAL),
    .BIDX_W   (BIDX_W)
  ) u_ref (
    .clk     (clk),
    .rst     (rst),
    .fire    (ref_fire),
    .pending (ref_pending),
    .target  (ref_target)
  );

  assign iss_valid   = found;
  assign iss_refresh = pick_ref;
  assign iss_write   = req_fire && head_wr[pick_bank];
  assign iss_bank    = pick_bank;

  // R5
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire |-> (old_ok[pick_bank] && act_ok[pick_rank]));
  // R9
  ref_act_chk: assert property (@(posedge clk) disable iff (rst)
    ref_fire |-> act_ok[pick_rank]);
  if (BUS_BUSY > 1) begin : g_gap
    // R2
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      iss_valid |=> !iss_valid);
  end
endmodule

// File: tb/dram_issue_arb_tb.sv
`timescale 1ns/1ps
module dram_issue_arb_tb;
  localparam int NB = 16;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // main instance: refresh effectively one-shot
  logic          d_in_valid = 0, d_in_write = 0, d_in_ready;
  logic [31:0]   d_in_addr = '0;
  logic [NR-1:0] d_act = '1;
  logic [NB-1:0] d_old = '1;
  logic          d_v, d_rf, d_wr;
  logic [3:0]    d_bank;

  dram_issue_arb #(.REFRESH_PERIOD(16 * 100000)) u_dut (
    .clk(clk), .rst(rst), .in_valid(d_in_valid), .in_addr(d_in_addr),
    .in_write(d_in_write), .in_ready(d_in_ready), .act_ok(d_act), .old_ok(d_old),
    .iss_valid(d_v), .iss_refresh(d_rf), .iss_write(d_wr), .iss_bank(d_bank));

  // refresh instance: interval 8 cycles
  logic          r_in_valid = 0, r_in_ready;
  logic [31:0]   r_in_addr = '0;
  logic [NR-1:0] r_act = '1;
  logic [NB-1:0] r_old = '0;
  logic          r_v, r_rf, r_wr;
  logic [3:0]    r_bank;

  dram_issue_arb #(.REFRESH_PERIOD(128)) u_refdut (
    .clk(clk), .rst(rst), .in_valid(r_in_valid), .in_addr(r_in_addr),
    .in_write(1'b0), .in_ready(r_in_ready), .act_ok(r_act), .old_ok(r_old),
    .iss_valid(r_v), .iss_refresh(r_rf), .iss_write(r_wr), .iss_bank(r_bank));

  int d_n = 0, d_cyc[256], d_bk[256], d_w[256], d_r[256];
  int r_n = 0, r_cyc[256], r_bk[256], r_w[256], r_r[256];

  always @(negedge clk) begin
    if (!rst && d_v && d_n < 256) begin
      d_cyc[d_n] = cyc; d_bk[d_n] = d_bank; d_w[d_n] = d_wr; d_r[d_n] = d_rf; d_n++;
    end
    if (!rst && r_v && r_n < 256) begin
      r_cyc[r_n] = cyc; r_bk[r_n] = r_bank; r_w[r_n] = r_wr; r_r[r_n] = r_rf; r_n++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) step();
  endtask

  // R1 address layout: bank at bit 6, rank at bit 8, dimm at bit 9; junk elsewhere
  function automatic logic [31:0] mk_addr(input int d, input int r, input int b);
    return 32'h5A5A_0000 | 32'(d << 9) | 32'(r << 8) | 32'(b << 6) | 32'h15;
  endfunction
  function automatic int gidx(input int d, input int r, input int b);
    return d * 8 + r * 4 + b;
  endfunction

  task automatic push_d(input int d, input int r, input int b, input logic w);
    d_in_addr = mk_addr(d, r, b); d_in_write = w; d_in_valid = 1'b1;
    step();
    d_in_valid = 1'b0;
  endtask

  typedef struct packed {
    logic w1; logic d1; logic r1; logic [1:0] b1;
    logic w2; logic d2; logic r2; logic [1:0] b2;
    logic [3:0] gap;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 4'd2},  // R2 read, read same rank
    '{1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 4'd3},  // R3 read then write
    '{1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 4'd3},  // R3 read, other rank
    '{1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd3},  // R3 read, other dimm
    '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 2'd2, 4'd2},  // R4 write then read
    '{1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd3, 4'd2},  // R4 write then write
    '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 4'd6},  // R2 same bank
    '{1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 2'd3, 4'd6}   // R2 same bank
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base, p, q;
    wait_to(3);
    // R11 reset state
    chk("R11 iss_valid in reset", d_v, 0);
    chk("R11 in_ready in reset", d_in_ready, 1);
    wait_to(4);
    rst = 1'b0;   // released in cycle 4

    // R10: refresh and request of bank 2 eligible together (refresh #18 due at 149)
    wait_to(145);
    r_in_addr = mk_addr(0, 0, 2); r_in_valid = 1'b1;
    step();
    r_in_valid = 1'b0;
    wait_to(149);
    r_old = '1;
    // R9 blocked by act_ok
    wait_to(160);
    r_act = '0;
    wait_to(200);
    chk("R9 no refresh while act_ok low", r_n, 21);
    r_act = '1;
    wait_to(210);

    // R8 periodic refresh, pointer walk and wrap; R9 refresh ignores old_ok
    for (int k = 0; k < 18; k++) begin
      chk("R8 refresh bank", r_bk[k], k % 16);
      chk("R8 refresh cycle", r_cyc[k], 5 + 8 * k);
      chk("R9 refresh flag", r_r[k], 1);
    end
    chk("R10 refresh first bank", r_bk[18], 2);
    chk("R10 refresh first flag", r_r[18], 1);
    chk("R10 refresh first cycle", r_cyc[18], 149);
    chk("R10 request after bank busy flag", r_r[19], 0);
    chk("R10 request after bank busy cycle", r_cyc[19], 155);
    chk("R10 request bank", r_bk[19], 2);
    chk("R9 backlog first bank", r_bk[21], 4);
    chk("R9 backlog first cycle", r_cyc[21], 200);
    chk("R9 backlog second bank", r_bk[22], 5);
    chk("R9 backlog spacing", r_cyc[22] - r_cyc[21], 2);

    // R8 first refresh of main instance
    chk("R8 first refresh cycle", d_cyc[0], 5);
    chk("R8 first refresh bank", d_bk[0], 0);
    chk("R8 first refresh flag", d_r[0], 1);

    // vector table: two requests, expected spacing
    for (int v = 0; v < 8; v++) begin
      wait_to(cyc + 10);
      base = d_n;
      p = cyc;
      push_d(VEC[v].d1, VEC[v].r1, VEC[v].b1, VEC[v].w1);
      push_d(VEC[v].d2, VEC[v].r2, VEC[v].b2, VEC[v].w2);
      wait_to(p + 12);
      chk("R6 vector issue count", d_n - base, 2);
      chk("R1 vector first bank", d_bk[base], gidx(VEC[v].d1, VEC[v].r1, VEC[v].b1));
      chk("R6 vector first cycle", d_cyc[base], p + 1);
      chk("R6 vector first type", d_w[base], VEC[v].w1);
      chk("R1 vector second bank", d_bk[base + 1], gidx(VEC[v].d2, VEC[v].r2, VEC[v].b2));
      chk("R6 vector second type", d_w[base + 1], VEC[v].w2);
      chk("R3 R4 vector gap", d_cyc[base + 1] - d_cyc[base], VEC[v].gap);
    end

    // R5 old_ok gating
    wait_to(cyc + 10);
    d_old[5] = 1'b0;
    base = d_n;
    push_d(0, 1, 1, 1'b0);
    wait_to(cyc + 6);
    chk("R5 held by old_ok", d_n - base, 0);
    q = cyc; d_old[5] = 1'b1;
    step();
    chk("R5 released by old_ok cycle", d_cyc[base], q);
    chk("R5 released bank", d_bk[base], 5);

    // R5 act_ok gating (rank 2 = dimm 1 rank 0)
    wait_to(cyc + 10);
    d_act[2] = 1'b0;
    base = d_n;
    push_d(1, 0, 1, 1'b1);
    wait_to(cyc + 6);
    chk("R5 held by act_ok", d_n - base, 0);
    q = cyc; d_act[2] = 1'b1;
    step();
    chk("R5 released by act_ok cycle", d_cyc[base], q);
    chk("R5 released write type", d_w[base], 1);

    // R6 full queue blocks input
    wait_to(cyc + 10);
    d_old[3] = 1'b0;
    base = d_n;
    push_d(0, 0, 3, 1'b0);
    push_d(0, 0, 3, 1'b0);
    d_in_addr = mk_addr(0, 1, 0); #0.5;
    chk("R6 other bank ready", d_in_ready, 1);
    d_in_addr = mk_addr(0, 0, 3); d_in_write = 1'b1; d_in_valid = 1'b1; #0.5;
    chk("R6 full bank not ready", d_in_ready, 0);
    step();
    d_in_valid = 1'b0;
    step();
    q = cyc; d_old[3] = 1'b1;
    wait_to(q + 20);
    chk("R6 only queued entries issue", d_n - base, 2);
    chk("R6 first read", d_w[base], 0);
    chk("R6 second read", d_w[base + 1], 0);
    chk("R6 first cycle", d_cyc[base], q);
    chk("R2 same bank spacing", d_cyc[base + 1] - d_cyc[base], 6);

    // R7 round robin from last issued bank
    wait_to(cyc + 10);
    push_d(0, 0, 2, 1'b0);
    wait_to(cyc + 8);
    d_old[1] = 1'b0; d_old[3] = 1'b0;
    base = d_n;
    push_d(0, 0, 1, 1'b0);
    push_d(0, 0, 3, 1'b0);
    step();
    q = cyc; d_old[1] = 1'b1; d_old[3] = 1'b1;
    wait_to(q + 6);
    chk("R7 after bank 2 picks bank 3", d_bk[base], 3);
    chk("R7 then bank 1", d_bk[base + 1], 1);
    chk("R7 first pick cycle", d_cyc[base], q);
    wait_to(cyc + 10);
    d_old[0] = 1'b0; d_old[2] = 1'b0;
    base = d_n;
    push_d(0, 0, 0, 1'b0);
    push_d(0, 0, 2, 1'b0);
    step();
    q = cyc; d_old[0] = 1'b1; d_old[2] = 1'b1;
    wait_to(q + 6);
    chk("R7 after bank 1 picks bank 2", d_bk[base], 2);
    chk("R7 then bank 0", d_bk[base + 1], 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule